// File: doc/BRIEF.md
# Unified Memory-Mapped Data Store

This block places three storage regions behind a single word-addressed port. The regions are a general-purpose data RAM, a screen frame buffer and a one-word keyboard register. A processor-side master presents an address, a write word and a write strobe. It reads back a 16-bit word combinationally from whichever region the address selects.

The region sizes are set by two parameters: the data RAM holds 2^RAM_AW words and the frame buffer holds 2^SCR_AW words. The regions are packed in this order. The data RAM starts at address 0 and the frame buffer follows it directly. The keyboard register sits on the single address after the frame buffer. Every address above the keyboard register is invalid.

With RAM_AW=14 and SCR_AW=13, the address is 15 bits wide and the frame buffer begins at 0x4000. In that configuration the keyboard register sits at 0x6000 and everything from 0x6001 upward is invalid. The default parameters build a smaller map of the same shape: RAM_AW=11 and SCR_AW=10, with the frame buffer at 0x800, the keyboard at 0xC00 and invalid addresses from 0xC01 to 0xFFF. A second read-only port into the frame buffer lets a display engine scan pixels out independently. The keyboard register samples an external scan-code input on every clock. All interfaces are plain, with no handshake: every read completes in the cycle it is presented, and a write never stalls.

Top module: `mm_unified_mem`

## Requirements
- R1: Addresses 0 to 2^RAM_AW-1 select the data RAM. A write there with we_i high is read back unchanged at the same address on any later cycle.
- R2: Addresses from 2^RAM_AW up to 2^RAM_AW+2^SCR_AW-1 select the frame buffer at local index (address − 2^RAM_AW). A word written there is returned on rd_data_o and also on scan_data_o when scan_addr_i equals that local index.
- R3: The address 2^RAM_AW+2^SCR_AW reads the keyboard register. On each rising clock edge outside reset, the register captures kbd_code_i, so the read shows the code from the previous cycle (0 means no key).
- R4: A write to the keyboard address has no effect: the register continues to follow kbd_code_i.
- R5: Any address above the keyboard address reads as 0. In the same cycle, bad_addr_o is 1. For every other address, bad_addr_o is 0.
- R6: A write to an invalid address changes no storage. This includes the RAM and frame-buffer words whose index matches the address's low bits.
- R7: When we_i is low, no region is modified, whatever wr_data_i holds.
- R8: Reads are combinational: rd_data_o reflects the word at the present addr_i within the same cycle, with no added latency.
- R9: While rst_ni is low, the keyboard register holds 0.
- R10: The regions are separate: a frame-buffer write does not alter the data RAM word that has the same local index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes and keyboard sampling on its rising edge |
| rst_ni | input | 1 | Active-low reset of the keyboard register |
| addr_i | input | ADDR_W | Word address into the unified map |
| wr_data_i | input | DW | Word to store |
| we_i | input | 1 | Write strobe |
| rd_data_o | output | DW | Word at addr_i (0 for invalid addresses) |
| bad_addr_o | output | 1 | High while addr_i is above the keyboard address |
| kbd_code_i | input | DW | Scan code of the pressed key, 0 if none |
| scan_addr_i | input | SCR_AW | Frame-buffer index for display scan-out |
| scan_data_o | output | DW | Frame-buffer word at scan_addr_i |

## Verification
The embedded properties check four things every cycle. First, a valid RAM or frame-buffer write reads back on the next cycle at the same address. Second, the scan port returns a frame-buffer word written through the main port. Third, invalid addresses always read zero. Fourth, the keyboard address returns the scan code from the previous cycle, whether or not it was written. Some behaviours can only be shown by the bench's scenarios: that a blocked or invalid write leaves a specific aliased RAM or frame-buffer word intact, that the regions do not overlap at matching low bits, that the reset value holds, and that the region boundaries lie exactly at their edge addresses.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    REG_RAM = 2'd0,
    REG_SCR = 2'd1,
    REG_KBD = 2'd2,
    REG_BAD = 2'd3
  } region_e;
endpackage

// File: rtl/mm_decode.sv
module mm_decode
  import mm_pkg::*;
#(
  parameter int RAM_AW = 11,
  parameter int SCR_AW = 10,
  parameter int ADDR_W = RAM_AW + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [RAM_AW-1:0] ram_idx_o,
  output logic [SCR_AW-1:0] scr_idx_o
);
  localparam logic [ADDR_W-1:0] SCR_BASE = ADDR_W'(1 << RAM_AW);
  localparam logic [ADDR_W-1:0] KBD_ADDR = ADDR_W'((1 << RAM_AW) + (1 << SCR_AW));

  always_comb begin
    if (addr_i < SCR_BASE)       region_o = REG_RAM;
    else if (addr_i < KBD_ADDR)  region_o = REG_SCR;
    else if (addr_i == KBD_ADDR) region_o = REG_KBD;
    else                         region_o = REG_BAD;
  end

  assign ram_idx_o = addr_i[RAM_AW-1:0];
  assign scr_idx_o = addr_i[SCR_AW-1:0] - SCR_BASE[SCR_AW-1:0];
endmodule

// File: rtl/mm_bank.sv
module mm_bank #(
  parameter int AW      = 10,
  parameter int DW      = 16,
  parameter bit SCAN_EN = 1'b0
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [AW-1:0] scan_addr_i,
  output logic [DW-1:0] scan_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];

  generate
    if (SCAN_EN) begin : g_scan
      assign scan_data_o = mem[scan_addr_i];
    end else begin : g_noscan
      logic scan_unused;
      assign scan_unused = ^scan_addr_i;
      assign scan_data_o = '0;
    end
  endgenerate
endmodule

// File: rtl/mm_kbd_reg.sv
module mm_kbd_reg #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] code_i,
  output logic [DW-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_o <= '0;
    else         code_o <= code_i;
  end
endmodule

// File: rtl/mm_unified_mem.sv
module mm_unified_mem
  import mm_pkg::*;
#(
  parameter int RAM_AW = 11,
  parameter int SCR_AW = 10,
  parameter int DW     = 16,
  parameter int ADDR_W = RAM_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              we_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              bad_addr_o,
  input  logic [DW-1:0]     kbd_code_i,
  input  logic [SCR_AW-1:0] scan_addr_i,
  output logic [DW-1:0]     scan_data_o
);
  localparam logic [ADDR_W-1:0] KBD_ADDR = ADDR_W'((1 << RAM_AW) + (1 << SCR_AW));

  region_e           region;
  logic [RAM_AW-1:0] ram_idx;
  logic [SCR_AW-1:0] scr_idx;
  logic [DW-1:0]     ram_rd, scr_rd, kbd_q, ram_scan_unused;
  logic              ram_we, scr_we;

  mm_decode #(.RAM_AW(RAM_AW), .SCR_AW(SCR_AW), .ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .region_o (region),
    .ram_idx_o(ram_idx),
    .scr_idx_o(scr_idx)
  );

  assign ram_we = we_i && (region == REG_RAM);
  assign scr_we = we_i && (region == REG_SCR);

  mm_bank #(.AW(RAM_AW), .DW(DW), .SCAN_EN(1'b0)) u_ram (
    .clk_i      (clk_i),
    .we_i       (ram_we),
    .addr_i     (ram_idx),
    .wdata_i    (wr_data_i),
    .rdata_o    (ram_rd),
    .scan_addr_i('0),
    .scan_data_o(ram_scan_unused)
  );

  mm_bank #(.AW(SCR_AW), .DW(DW), .SCAN_EN(1'b1)) u_scr (
    .clk_i      (clk_i),
    .we_i       (scr_we),
    .addr_i     (scr_idx),
    .wdata_i    (wr_data_i),
    .rdata_o    (scr_rd),
    .scan_addr_i(scan_addr_i),
    .scan_data_o(scan_data_o)
  );

  mm_kbd_reg #(.DW(DW)) u_kbd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(kbd_code_i),
    .code_o(kbd_q)
  );

  always_comb begin
    unique case (region)
      REG_RAM: rd_data_o = ram_rd;
      REG_SCR: rd_data_o = scr_rd;
      REG_KBD: rd_data_o = kbd_q;
      default: rd_data_o = '0;
    endcase
  end

  assign bad_addr_o = (region == REG_BAD);

  // R1 R2
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && ($past(region) == REG_RAM || $past(region) == REG_SCR) &&
     addr_i == $past(addr_i)) |-> rd_data_o == $past(wr_data_i));

  // R2
  scan_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(scr_we) && scan_addr_i == $past(scr_idx)) |-> scan_data_o == $past(wr_data_i));

  // R5
  bad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_addr_o |-> rd_data_o == '0);

  // R3 R4
  kbd_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && addr_i == KBD_ADDR) |-> rd_data_o == $past(kbd_code_i));
endmodule

// File: tb/mm_unified_mem_tb.sv
`timescale 1ns/1ps
module mm_unified_mem_tb;
  localparam int RAM_AW = 11;
  localparam int SCR_AW = 10;
  localparam int ADDR_W = 12;
  localparam int SBASE  = 2048;
  localparam int KBD    = 3072;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       wdata = '0;
  logic              we = 1'b0;
  logic [15:0]       rdata;
  logic              bad;
  logic [15:0]       kbd = '0;
  logic [SCR_AW-1:0] saddr = '0;
  logic [15:0]       sdata;

  always #2 clk = ~clk;

  mm_unified_mem #(.RAM_AW(RAM_AW), .SCR_AW(SCR_AW), .DW(16), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_data_i(wdata), .we_i(we),
    .rd_data_o(rdata), .bad_addr_o(bad), .kbd_code_i(kbd),
    .scan_addr_i(saddr), .scan_data_o(sdata)
  );

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  item_t       it;
  logic [15:0] act;
  always @(negedge clk) begin
    while (q.size() > 0) begin
      it = q.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = sdata;
        default: act = {15'd0, bad};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(input int a, input logic w, input logic [15:0] d,
                      input int sa, input logic [15:0] kb);
    @(posedge clk);
    #1;
    addr  = ADDR_W'(a);
    we    = w;
    wdata = d;
    saddr = SCR_AW'(sa);
    kbd   = kb;
  endtask

  task automatic expect_item(input int kind, input logic [15:0] e, input string r);
    item_t x;
    x.kind = kind; x.exp = e; x.req = r;
    q.push_back(x);
  endtask

  initial begin
    // R9: reset holds keyboard register at 0 despite a live code
    step(KBD, 1'b0, 16'h0, 0, 16'h5A5A);
    step(KBD, 1'b0, 16'h0, 0, 16'h5A5A);
    expect_item(0, 16'h0000, "R9");
    step(0, 1'b0, 16'h0, 0, 16'h0000);
    rst_n = 1'b1;

    // R1
    step(5, 1'b1, 16'hA001, 0, 16'h0);
    step(5, 1'b0, 16'h0, 0, 16'h0);         expect_item(0, 16'hA001, "R1");
    step(2047, 1'b1, 16'hBEEF, 0, 16'h0);
    step(2047, 1'b0, 16'h0, 0, 16'h0);      expect_item(0, 16'hBEEF, "R1");
    step(2047, 1'b0, 16'h0, 0, 16'h0);      expect_item(2, 16'h0000, "R5");
    // R7
    step(5, 1'b0, 16'hFFFF, 0, 16'h0);
    step(5, 1'b0, 16'h0, 0, 16'h0);         expect_item(0, 16'hA001, "R7");
    // R2 / R10
    step(SBASE + 5, 1'b1, 16'hC0DE, 5, 16'h0);
    step(SBASE + 5, 1'b0, 16'h0, 5, 16'h0); expect_item(0, 16'hC0DE, "R2");
                                            expect_item(1, 16'hC0DE, "R2");
    step(5, 1'b0, 16'h0, 5, 16'h0);         expect_item(0, 16'hA001, "R10");
    step(SBASE + 1023, 1'b1, 16'h1357, 0, 16'h0);
    step(SBASE + 1023, 1'b0, 16'h0, 1023, 16'h0);
                                            expect_item(0, 16'h1357, "R2");
                                            expect_item(1, 16'h1357, "R2");
    // R8: back-to-back addresses, no latency
    step(5, 1'b0, 16'h0, 0, 16'h0);         expect_item(0, 16'hA001, "R8");
    step(SBASE + 5, 1'b0, 16'h0, 0, 16'h0); expect_item(0, 16'hC0DE, "R8");
    step(2047, 1'b0, 16'h0, 0, 16'h0);      expect_item(0, 16'hBEEF, "R8");
    // R3 / R4
    step(KBD, 1'b0, 16'h0, 0, 16'h0041);    expect_item(0, 16'h0000, "R3");
    step(KBD, 1'b0, 16'h0, 0, 16'h0041);    expect_item(0, 16'h0041, "R3");
                                            expect_item(2, 16'h0000, "R5");
    step(KBD, 1'b1, 16'h7777, 0, 16'h0041);
    step(KBD, 1'b0, 16'h0, 0, 16'h0041);    expect_item(0, 16'h0041, "R4");
    step(KBD, 1'b0, 16'h0, 0, 16'h0000);
    step(KBD, 1'b0, 16'h0, 0, 16'h0000);    expect_item(0, 16'h0000, "R3");
    // R5
    step(KBD + 1, 1'b0, 16'h0, 0, 16'h0);   expect_item(0, 16'h0000, "R5");
                                            expect_item(2, 16'h0001, "R5");
    step(4095, 1'b0, 16'h0, 0, 16'h0);      expect_item(0, 16'h0000, "R5");
                                            expect_item(2, 16'h0001, "R5");
    step(0, 1'b0, 16'h0, 0, 16'h0);         expect_item(2, 16'h0000, "R5");
    // R6: invalid 0xC05 aliases RAM 0x405 and screen index 5
    step(1029, 1'b1, 16'h2222, 0, 16'h0);
    step(3077, 1'b1, 16'h9999, 0, 16'h0);
    step(1029, 1'b0, 16'h0, 5, 16'h0);      expect_item(0, 16'h2222, "R6");
                                            expect_item(1, 16'hC0DE, "R6");
    step(0, 1'b0, 16'h0, 0, 16'h0);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule